// File: doc/BRIEF.md
# AES Decryption Start-Key Extractor

This block holds a raw AES cipher key of 128, 192 or 256 bits. On demand, it produces the round-key words that an inverse-cipher datapath needs before its first round. It runs the forward key expansion one 32-bit word per clock and keeps a sliding window of the most recent words. As the final schedule words go past, it captures them into an eight-word output buffer. The position each word takes depends on the key size. For 192-bit keys, two schedule words appear in both halves of the buffer.

Recomputation is lazy. Storing a new key only marks the buffer as stale. The expansion runs only when a decrypt request arrives while the buffer is stale, and the stale mark is then cleared. A request that arrives while the buffer is current is acknowledged at once, and the buffer is left as it is. The surrounding engine stores a key with `load`, and it issues `dec_req` before every decrypt job. It then waits for `done` and reads `dkey_out`.

Top module: `aesdk_top`

## Requirements
- R1: After reset, `busy`, `done` and `key_err` are low and `dkey_out` is all zero.
- R2: Key size is coded on `keylen`: 0 selects 128 bits, 1 selects 192 bits and 2 selects 256 bits. The key is left-aligned in `key_in`, so word 0 is `key_in[255:224]`. A `load` while idle with one of these codes stores the key, marks the buffer stale and drives `key_err` low on the next cycle.
- R3: A `load` while idle with `keylen` = 3 drives `key_err` high on the next cycle. It leaves the stored key and the stale mark unchanged.
- R4: For a 128-bit key, slots 0..3 receive schedule words 40..43 and slots 4..7 keep their previous contents. Slot k is `dkey_out[255-32k -: 32]`.
- R5: For a 192-bit key, slots 0..3 receive schedule words 48..51 and slots 4..7 receive schedule words 46..49.
- R6: For a 256-bit key, slots 0..3 receive schedule words 56..59 and slots 4..7 receive schedule words 52..55.
- R7: A `dec_req` while idle with the buffer stale raises `busy` on the next cycle. `done` is registered high, with `busy` low, at the clock edge that comes 3*Nk+28 edges after the edge that sampled the request (40, 46 or 52). Nk is the key length in words.
- R8: A `dec_req` while idle with the buffer current registers `done` at the sampling edge itself, with no expansion. `dkey_out` changes only while `busy` is high.
- R9: A completed expansion clears the stale mark, so the next request takes the R8 path and returns the same buffer.
- R10: While `busy` is high, `load` and `dec_req` are ignored: stored key, `key_err`, stale mark and the result in flight are unaffected.
- R11: When `load` and `dec_req` are both high in the same idle cycle, the load is taken and the request is dropped: no `done` and no `busy` follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_in | input | 256 | Left-aligned cipher key |
| keylen | input | 2 | Key size code (0/1/2 valid, 3 rejected) |
| load | input | 1 | Store key_in when idle |
| dec_req | input | 1 | Request a current decryption start key |
| busy | output | 1 | Expansion in progress |
| done | output | 1 | One-cycle acknowledge of a request |
| key_err | output | 1 | Last accepted load had an invalid size code |
| dkey_out | output | 256 | Eight-word start-key buffer, slot 0 at the top |

## Verification
The expansion is exercised with the three published example keys of the AES standard, one per size. For these keys, known tail words separate a wrong recurrence (rotation, substitution or round-constant sequencing) from a wrong slot placement. Seeded random keys across all three sizes are then run in sequence, with no reset between them. In that sequence the 128-bit cases show whether slots 4..7 really carry over from the previous key, and the 192-bit cases check the overlapped placement. Directed sequences separate a stale buffer from a current one through the `done` latency. They also send loads and requests during a run and in the same cycle, to show which stimulus is dropped.

// File: rtl/aesdk_pkg.sv
package aesdk_pkg;

  typedef enum logic [1:0] {
    KSZ_128 = 2'd0,
    KSZ_192 = 2'd1,
    KSZ_256 = 2'd2,
    KSZ_BAD = 2'd3
  } key_size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

  function automatic logic [7:0] gf_xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = 8'h00;
    x   = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ x;
      x = gf_xtime(x);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254 (maps 0 to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] base;
    logic [7:0] e;
    r    = 8'h01;
    base = a;
    e    = 8'd254;
    for (int k = 0; k < 8; k++) begin
      if (e[k]) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox_fwd(input logic [7:0] b);
    logic [7:0] v;
    v = gf_inv(b);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^
           {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/aesdk_subword.sv
module aesdk_subword #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  import aesdk_pkg::*;

  localparam int NBYTES = WORD_W / 8;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_comb begin
      word_o[g*8 +: 8] = sbox_fwd(word_i[g*8 +: 8]);
    end
  end

endmodule

// File: rtl/aesdk_word_step.sv
module aesdk_word_step #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] prev_w,
  input  logic [WORD_W-1:0] far_w,
  input  logic              rot_en,
  input  logic              sub_only,
  input  logic [7:0]        rcon,
  output logic [WORD_W-1:0] next_w
);
  logic [WORD_W-1:0] sub_in;
  logic [WORD_W-1:0] sub_out;
  logic [WORD_W-1:0] mixed;

  always_comb begin
    sub_in = rot_en ? {prev_w[WORD_W-9:0], prev_w[WORD_W-1 -: 8]} : prev_w;
  end

  aesdk_subword #(.WORD_W(WORD_W)) u_sub (
    .word_i (sub_in),
    .word_o (sub_out)
  );

  always_comb begin
    if (rot_en) begin
      mixed = sub_out ^ {rcon, {(WORD_W-8){1'b0}}};
    end else if (sub_only) begin
      mixed = sub_out;
    end else begin
      mixed = prev_w;
    end
    next_w = far_w ^ mixed;
  end

endmodule

// File: rtl/aesdk_sched.sv
module aesdk_sched #(
  parameter int WORD_W = 32,
  parameter int MAX_NK = 8,
  parameter int IDX_W  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     step,
  input  logic [3:0]               nk,
  input  logic [MAX_NK*WORD_W-1:0] key_words,
  output logic [IDX_W-1:0]         idx,
  output logic [WORD_W-1:0]        new_word
);
  import aesdk_pkg::*;

  localparam int PH_W  = $clog2(MAX_NK);
  localparam int SEL_W = $clog2(MAX_NK);

  logic [WORD_W-1:0] win_q [MAX_NK];
  logic [WORD_W-1:0] win_d [MAX_NK];
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic [7:0]        rc_q, rc_d;
  logic [SEL_W-1:0]  far_sel;
  logic              rot_en, sub_only, adv;

  assign far_sel  = SEL_W'(nk - 4'd1);
  assign rot_en   = (ph_q == '0);
  assign sub_only = (nk > 4'd6) && (ph_q == PH_W'(4));
  assign adv      = start | step;

  aesdk_word_step #(.WORD_W(WORD_W)) u_step (
    .prev_w   (win_q[0]),
    .far_w    (win_q[far_sel]),
    .rot_en   (rot_en),
    .sub_only (sub_only),
    .rcon     (rc_q),
    .next_w   (new_word)
  );

  always_comb begin
    idx_d = idx_q;
    ph_d  = ph_q;
    rc_d  = rc_q;
    for (int j = 0; j < MAX_NK; j++) win_d[j] = win_q[j];
    if (start) begin
      idx_d = IDX_W'(nk);
      ph_d  = '0;
      rc_d  = 8'h01;
      for (int j = 0; j < MAX_NK; j++) begin
        if (j < int'(nk)) begin
          win_d[j] = key_words[(MAX_NK - int'(nk) + 1 + j)*WORD_W - 1 -: WORD_W];
        end else begin
          win_d[j] = '0;
        end
      end
    end else if (step) begin
      idx_d = idx_q + 1'b1;
      ph_d  = (ph_q == PH_W'(nk - 4'd1)) ? '0 : ph_q + 1'b1;
      if (rot_en) rc_d = gf_xtime(rc_q);
      win_d[0] = new_word;
      for (int j = 1; j < MAX_NK; j++) win_d[j] = win_q[j-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ph_q  <= '0;
      rc_q  <= 8'h01;
      for (int j = 0; j < MAX_NK; j++) win_q[j] <= '0;
    end else if (adv) begin
      idx_q <= idx_d;
      ph_q  <= ph_d;
      rc_q  <= rc_d;
      for (int j = 0; j < MAX_NK; j++) win_q[j] <= win_d[j];
    end
  end

  assign idx = idx_q;

endmodule

// File: rtl/aesdk_ctrl.sv
module aesdk_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic len_ok,
  input  logic dec_req,
  input  logic last_word,
  output logic busy,
  output logic done,
  output logic key_err,
  output logic start,
  output logic step,
  output logic key_we
);
  import aesdk_pkg::*;

  run_state_e st_q, st_d;
  logic dirty_q, dirty_d;
  logic done_q, done_d;
  logic err_q, err_d;

  always_comb begin
    st_d    = st_q;
    dirty_d = dirty_q;
    err_d   = err_q;
    done_d  = 1'b0;
    start   = 1'b0;
    step    = 1'b0;
    key_we  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (load) begin
          if (len_ok) begin
            key_we  = 1'b1;
            dirty_d = 1'b1;
            err_d   = 1'b0;
          end else begin
            err_d = 1'b1;
          end
        end else if (dec_req) begin
          if (dirty_q) begin
            start = 1'b1;
            st_d  = ST_RUN;
          end else begin
            done_d = 1'b1;
          end
        end
      end
      ST_RUN: begin
        step = 1'b1;
        if (last_word) begin
          st_d    = ST_IDLE;
          dirty_d = 1'b0;
          done_d  = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      dirty_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      dirty_q <= dirty_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy    = (st_q == ST_RUN);
  assign done    = done_q;
  assign key_err = err_q;

endmodule

// File: rtl/aesdk_top.sv
module aesdk_top #(
  parameter int WORD_W = 32,
  parameter int MAX_NK = 8,
  parameter int IDX_W  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [MAX_NK*WORD_W-1:0] key_in,
  input  logic [1:0]               keylen,
  input  logic                     load,
  input  logic                     dec_req,
  output logic                     busy,
  output logic                     done,
  output logic                     key_err,
  output logic [MAX_NK*WORD_W-1:0] dkey_out
);
  import aesdk_pkg::*;

  localparam int KEY_W  = MAX_NK * WORD_W;
  localparam int HALF   = MAX_NK / 2;

  logic [KEY_W-1:0]  key_q;
  logic [3:0]        nk_q, nk_in;
  logic              len_ok, start, step, key_we, last_word;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] new_word;
  logic [WORD_W-1:0] dk_q [MAX_NK];
  logic [WORD_W-1:0] dk_d [MAX_NK];
  logic              dk_we;

  always_comb begin
    len_ok = 1'b1;
    case (key_size_e'(keylen))
      KSZ_128: nk_in = 4'd4;
      KSZ_192: nk_in = 4'd6;
      KSZ_256: nk_in = 4'd8;
      default: begin
        nk_in  = 4'd4;
        len_ok = 1'b0;
      end
    endcase
  end

  aesdk_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .len_ok    (len_ok),
    .dec_req   (dec_req),
    .last_word (last_word),
    .busy      (busy),
    .done      (done),
    .key_err   (key_err),
    .start     (start),
    .step      (step),
    .key_we    (key_we)
  );

  aesdk_sched #(.WORD_W(WORD_W), .MAX_NK(MAX_NK), .IDX_W(IDX_W)) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .step      (step),
    .nk        (nk_q),
    .key_words (key_q),
    .idx       (idx),
    .new_word  (new_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      nk_q  <= 4'd4;
    end else if (key_we) begin
      key_q <= key_in;
      nk_q  <= nk_in;
    end
  end

  // primary group starts at 4*Nk+24, secondary at 3*Nk+28 (192/256 only)
  always_comb begin
    int ix, base_a, base_b;
    ix        = int'(idx);
    base_a    = 4 * int'(nk_q) + 24;
    base_b    = 3 * int'(nk_q) + 28;
    last_word = (ix == base_a + HALF - 1);
    dk_we     = 1'b0;
    for (int j = 0; j < MAX_NK; j++) dk_d[j] = dk_q[j];
    if (step) begin
      for (int j = 0; j < HALF; j++) begin
        if (ix == base_a + j) begin
          dk_d[j] = new_word;
          dk_we   = 1'b1;
        end
        if ((nk_q != 4'd4) && (ix == base_b + j)) begin
          dk_d[HALF + j] = new_word;
          dk_we          = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < MAX_NK; j++) dk_q[j] <= '0;
    end else if (dk_we) begin
      for (int j = 0; j < MAX_NK; j++) dk_q[j] <= dk_d[j];
    end
  end

  for (genvar g = 0; g < MAX_NK; g++) begin : g_out
    assign dkey_out[KEY_W-1-g*WORD_W -: WORD_W] = dk_q[g];
  end

endmodule

// File: rtl/aesdk_chk.sv
module aesdk_chk #(
  parameter int KEY_W = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       keylen,
  input logic             load,
  input logic             dec_req,
  input logic             busy,
  input logic             done,
  input logic             key_err,
  input logic [KEY_W-1:0] dkey_out
);

  p_good_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && load && keylen != 2'd3) |=> !key_err);

  p_bad_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && load && keylen == 2'd3) |=> key_err);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(dkey_out));

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load) |=> $stable(key_err));

  p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && load && dec_req) |=> (!busy && !done));

endmodule

bind aesdk_top aesdk_chk #(.KEY_W(256)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .keylen   (keylen),
  .load     (load),
  .dec_req  (dec_req),
  .busy     (busy),
  .done     (done),
  .key_err  (key_err),
  .dkey_out (dkey_out)
);

// File: tb/aesdk_tb.sv
module aesdk_top_tb_top;

  logic         clk;
  logic         rst_n;
  logic [255:0] key_in;
  logic [1:0]   keylen;
  logic         load;
  logic         dec_req;
  logic         busy;
  logic         done;
  logic         key_err;
  logic [255:0] dkey_out;

  int n_tests;
  int n_fail;
  int cyc;

  logic [7:0]   sb_t [256];
  logic [31:0]  rw [60];
  logic [255:0] mdl;

  aesdk_top dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_in   (key_in),
    .keylen   (keylen),
    .load     (load),
    .dec_req  (dec_req),
    .busy     (busy),
    .done     (done),
    .key_err  (key_err),
    .dkey_out (dkey_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_tests = n_tests + 1;
      n_fail  = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                     input logic [255:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bx(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  // S-box built from exp/log tables over generator 3
  task automatic build_sbox();
    logic [7:0] ex [256];
    int         lg [256];
    logic [7:0] pp, inv, s;
    pp = 8'h01;
    for (int i = 0; i < 255; i++) begin
      ex[i] = pp;
      lg[pp] = i;
      pp = pp ^ bx(pp);
    end
    for (int a = 0; a < 256; a++) begin
      inv = (a == 0) ? 8'h00 : ex[(255 - lg[a]) % 255];
      for (int b = 0; b < 8; b++) begin
        s[b] = inv[b] ^ inv[(b+4)%8] ^ inv[(b+5)%8] ^ inv[(b+6)%8] ^
               inv[(b+7)%8] ^ ((8'h63 >> b) & 8'h01) != 0;
      end
      sb_t[a] = s;
    end
  endtask

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sb_t[w[31:24]], sb_t[w[23:16]], sb_t[w[15:8]], sb_t[w[7:0]]};
  endfunction

  task automatic build_sched(input logic [255:0] k, input int nk);
    logic [31:0] t;
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < 60; i++) begin
      if (i < nk) begin
        rw[i] = k[255 - 32*i -: 32];
      end else begin
        t = rw[i-1];
        if (i % nk == 0) begin
          t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
          rc = bx(rc);
        end else if (nk == 8 && i % nk == 4) begin
          t = subw(t);
        end
        rw[i] = rw[i-nk] ^ t;
      end
    end
  endtask

  task automatic update_model(input int nk);
    int pa;
    pa = 4*nk + 24;
    for (int j = 0; j < 4; j++) mdl[255 - 32*j -: 32] = rw[pa + j];
    if (nk == 6) for (int j = 0; j < 4; j++) mdl[127 - 32*j -: 32] = rw[46 + j];
    if (nk == 8) for (int j = 0; j < 4; j++) mdl[127 - 32*j -: 32] = rw[52 + j];
  endtask

  task automatic do_load(input logic [255:0] k, input logic [1:0] kl);
    key_in = k;
    keylen = kl;
    load   = 1'b1;
    @(negedge clk);
    load   = 1'b0;
  endtask

  task automatic do_dec(output int n, output bit busy_first);
    dec_req = 1'b1;
    @(negedge clk);
    dec_req    = 1'b0;
    busy_first = busy;
    n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_key(input logic [255:0] k, input logic [1:0] kl, input string tag);
    int n;
    bit bf;
    int nk;
    nk = (kl == 2'd0) ? 4 : (kl == 2'd1) ? 6 : 8;
    do_load(k, kl);
    chk(key_err == 1'b0, "R2 key_err low after valid load", {255'h0, key_err}, 256'h0);
    do_dec(n, bf);
    chk(bf == 1'b1, "R7 busy after stale request", {255'h0, bf}, 256'h1);
    chk(n == 3*nk + 28, "R7 done latency", 256'(n), 256'(3*nk + 28));
    build_sched(k, nk);
    update_model(nk);
    chk(dkey_out == mdl, tag, dkey_out, mdl);
  endtask

  initial begin
    int n;
    bit bf;
    logic [255:0] k;
    logic [255:0] keep;
    logic [1:0]   kl;
    n_tests = 0;
    n_fail  = 0;
    cyc     = 0;
    rst_n   = 1'b0;
    key_in  = '0;
    keylen  = 2'd0;
    load    = 1'b0;
    dec_req = 1'b0;
    mdl     = '0;
    build_sbox();
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!busy && !done && !key_err, "R1 control outputs after reset",
        {253'h0, busy, done, key_err}, 256'h0);
    chk(dkey_out == '0, "R1 buffer after reset", dkey_out, 256'h0);

    // R8 request with nothing pending
    do_dec(n, bf);
    chk(n == 0 && !bf, "R8 immediate done with no pending key", 256'(n), 256'h0);
    chk(dkey_out == '0, "R8 buffer unchanged", dkey_out, 256'h0);

    // published example keys
    run_key({128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0}, 2'd0, "R4 128-bit example key");
    chk(dkey_out[255:128] == 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R4 known tail words",
        {128'h0, dkey_out[255:128]}, {128'h0, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6});
    chk(dkey_out[127:0] == '0, "R4 upper slots kept", {128'h0, dkey_out[127:0]}, 256'h0);
    run_key({192'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b, 64'h0}, 2'd1,
            "R5 192-bit example key");
    chk(dkey_out[159:128] == 32'h01002202, "R5 last schedule word",
        {224'h0, dkey_out[159:128]}, {224'h0, 32'h01002202});
    chk(dkey_out[255:192] == dkey_out[63:0], "R5 overlapped slots",
        {192'h0, dkey_out[255:192]}, {192'h0, dkey_out[63:0]});
    run_key(256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4, 2'd2,
            "R6 256-bit example key");
    chk(dkey_out[159:128] == 32'h706c631e, "R6 last schedule word",
        {224'h0, dkey_out[159:128]}, {224'h0, 32'h706c631e});

    // R9 reuse
    keep = dkey_out;
    do_dec(n, bf);
    chk(n == 0, "R9 second request takes no expansion", 256'(n), 256'h0);
    chk(dkey_out == keep, "R9 buffer reused", dkey_out, keep);

    // R3 invalid size: stored key and stale mark untouched
    k = {128'h000102030405060708090a0b0c0d0e0f, 128'h0};
    do_load(k, 2'd0);
    do_load({8{32'hdeadbeef}}, 2'd3);
    chk(key_err == 1'b1, "R3 key_err high", {255'h0, key_err}, 256'h1);
    do_dec(n, bf);
    chk(n == 40, "R3 pending key survives rejected load", 256'(n), 256'd40);
    build_sched(k, 4);
    update_model(4);
    chk(dkey_out == mdl, "R3 result from earlier valid key", dkey_out, mdl);
    do_load({8{32'h55aa55aa}}, 2'd3);
    do_dec(n, bf);
    chk(n == 0, "R3 rejected load does not mark stale", 256'(n), 256'h0);
    chk(dkey_out == mdl, "R3 buffer unchanged", dkey_out, mdl);

    // R10 load and request during a run
    k = {8{32'h13579bdf}};
    do_load(k, 2'd2);
    dec_req = 1'b1;
    @(negedge clk);
    dec_req = 1'b0;
    key_in  = {8{32'h2468ace0}};
    keylen  = 2'd3;
    load    = 1'b1;
    dec_req = 1'b1;
    repeat (4) @(negedge clk);
    load    = 1'b0;
    dec_req = 1'b0;
    chk(key_err == 1'b0, "R10 key_err untouched during run", {255'h0, key_err}, 256'h0);
    n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
    end
    build_sched(k, 8);
    update_model(8);
    chk(dkey_out == mdl, "R10 result of key in flight", dkey_out, mdl);
    do_dec(n, bf);
    chk(n == 0, "R10 no stale mark from ignored load", 256'(n), 256'h0);

    // R11 simultaneous load and request
    k = {192'hfedcba98765432100123456789abcdef0f1e2d3c4b5a6978, 64'h0};
    key_in  = k;
    keylen  = 2'd1;
    load    = 1'b1;
    dec_req = 1'b1;
    @(negedge clk);
    load    = 1'b0;
    dec_req = 1'b0;
    chk(!busy && !done, "R11 request dropped", {254'h0, busy, done}, 256'h0);
    @(negedge clk);
    chk(!busy && !done, "R11 still idle", {254'h0, busy, done}, 256'h0);
    do_dec(n, bf);
    chk(n == 46, "R11 key taken and stale", 256'(n), 256'd46);
    build_sched(k, 6);
    update_model(6);
    chk(dkey_out == mdl, "R11 result of loaded key", dkey_out, mdl);

    // seeded random keys of all sizes, no reset in between
    for (int r = 0; r < 15; r++) begin
      for (int w = 0; w < 8; w++) k[255 - 32*w -: 32] = $urandom;
      kl = 2'($urandom % 3);
      run_key(k, kl, (kl == 2'd0) ? "R4 random 128-bit key" :
                     (kl == 2'd1) ? "R5 random 192-bit key" : "R6 random 256-bit key");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule